// File: doc/BRIEF.md
# Enabled Address-Window Decoder

This block claims incoming 64-bit system addresses for four address windows: two general windows whose size comes from a programmable mask, a register window and an interrupt window, both of fixed size. Software programs the window bases, the two masks and an enable word through a small 64-bit register port. Each write is trimmed to the bits that the target register implements. The decoder then compares every presented address against the enabled windows. One clock later it reports which window won and the distance of the address from that window's base.

Live windows cannot be moved safely. A write to the base or mask of a window that is enabled is still stored, but it sets a sticky error flag. The flag stays set until reset. Reset clears every register, so all windows start disabled.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every register reads zero, no window claims any address, and `reprog_err` is low. A later reset clears a set error flag again.
- R2: The register slot is the byte address shifted right by 3. The slots are: 0 general-0 base, 1 general-0 mask, 2 general-1 base, 3 general-1 mask, 4 register-window base, 5 interrupt-window base, 6 enable. Slot 7 holds nothing: a write to it is dropped and a read of it returns zero.
- R3: A write keeps only the implemented bits of its target. General bases and masks keep bits 63:24. The register-window base keeps bits 63:22. The interrupt-window base keeps bits 63:36. The enable word keeps bits 63:60. All other bits are stored as zero.
- R4: The enable bits are: bit 63 general-0, bit 62 general-1, bit 61 register window, bit 60 interrupt window. A window whose bit is clear never claims an address.
- R5: A general window starts at its base register shifted right by 8. Its size is the complement of its mask register, shifted right by 8, plus one. It claims an address when base <= address < base + size.
- R6: The register window is `NUM_REGS`*8 bytes long and the interrupt window is `MAX_INTS`*65536 bytes long. Each starts at its base register shifted right by 8.
- R7: `hit` is one-hot: bit 0 general-0, bit 1 general-1, bit 2 register window, bit 3 interrupt window. When windows overlap, the lowest bit wins.
- R8: `hit_offset` equals the address minus the winning window's base. It is zero when no window claims the address.
- R9: `hit_vld`, `hit` and `hit_offset` appear on the clock edge after the address was presented with `addr_vld`. When `hit_vld` is low, `hit` is zero.
- R10: A write to a base or mask of a window whose enable bit is set is stored, and it sets `reprog_err`, which then stays high until reset. Writes to disabled windows or to the enable word do not set it.
- R11: A new enable word governs every address presented after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, updated on the edge that samples reg_rd |
| addr_vld | input | 1 | Address to decode is present |
| addr | input | ADDR_W | System address to decode |
| hit_vld | output | 1 | Decode result valid |
| hit | output | 4 | One-hot winning window |
| hit_offset | output | ADDR_W | Address minus winning window base |
| reprog_err | output | 1 | Sticky flag: an enabled window was reprogrammed |

## Verification
The assertions assume that `reg_wr`, `reg_rd` and `addr_vld` are known after reset and are never asserted together with an undefined address. They also assume the address port carries a full-word register index with the low three bits ignored. The stimulus drives every input on the falling edge and returns the strobes low after one cycle. It keeps `addr_vld` low while reset is applied, so the one-cycle latency property has a known starting point. Addresses are chosen at both edges of each window and in its overlaps, so the stimulus never needs a carry past bit 63.

// File: rtl/bar_win_pkg.sv
package bar_win_pkg;

   localparam int NWIN  = 4;
   localparam int NSLOT = 7;

   typedef enum logic [1:0] {
      WIN_GEN0 = 2'd0,
      WIN_GEN1 = 2'd1,
      WIN_REGS = 2'd2,
      WIN_INTR = 2'd3
   } win_e;

   localparam int SLOT_G0_BASE = 0;
   localparam int SLOT_G0_MASK = 1;
   localparam int SLOT_G1_BASE = 2;
   localparam int SLOT_G1_MASK = 3;
   localparam int SLOT_RG_BASE = 4;
   localparam int SLOT_IN_BASE = 5;
   localparam int SLOT_ENABLE  = 6;

   localparam logic [63:0] KEEP_GEN = 64'hFFFF_FFFF_FF00_0000;
   localparam logic [63:0] KEEP_RG  = 64'hFFFF_FFFF_FFC0_0000;
   localparam logic [63:0] KEEP_IN  = 64'hFFFF_FFF0_0000_0000;
   localparam logic [63:0] KEEP_EN  = 64'hF000_0000_0000_0000;

   // implemented bits of each slot
   function automatic logic [63:0] slot_keep(input int s);
      case (s)
         SLOT_G0_BASE, SLOT_G0_MASK,
         SLOT_G1_BASE, SLOT_G1_MASK: return KEEP_GEN;
         SLOT_RG_BASE:               return KEEP_RG;
         SLOT_IN_BASE:               return KEEP_IN;
         SLOT_ENABLE:                return KEEP_EN;
         default:                    return '0;
      endcase
   endfunction

   // window whose placement a slot defines, -1 for the enable word
   function automatic int slot_owner(input int s);
      case (s)
         SLOT_G0_BASE, SLOT_G0_MASK: return 0;
         SLOT_G1_BASE, SLOT_G1_MASK: return 1;
         SLOT_RG_BASE:               return 2;
         SLOT_IN_BASE:               return 3;
         default:                    return -1;
      endcase
   endfunction

endpackage

// File: rtl/bar_regfile.sv
module bar_regfile
   import bar_win_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  logic                       rd,
   input  logic [IDX_W-1:0]           idx,
   input  logic [63:0]                wdata,
   output logic [63:0]                rdata,
   output logic [NWIN-1:0][63:0]      base_o,
   output logic [1:0][63:0]           mask_o,
   output logic [NWIN-1:0]            en_o,
   output logic                       err_o
);

   logic [63:0]      store [NSLOT];
   logic [NSLOT-1:0] err_src;
   logic [63:0]      rd_mux;

   // one register per slot, trimmed to its implemented bits
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam logic [63:0] KEEP = slot_keep(s);
      localparam int          OWN  = slot_owner(s);

      always_ff @(posedge clk) begin
         if (!rst_n)
            store[s] <= '0;
         else if (wr && idx == IDX_W'(s))
            store[s] <= wdata & KEEP;
      end

      if (OWN >= 0) begin : g_own
         assign err_src[s] = wr && (idx == IDX_W'(s)) && en_o[OWN];
      end else begin : g_free
         assign err_src[s] = 1'b0;
      end
   end

   for (genvar w = 0; w < NWIN; w++) begin : g_en
      assign en_o[w] = store[SLOT_ENABLE][63-w];
   end

   assign base_o[0] = store[SLOT_G0_BASE];
   assign base_o[1] = store[SLOT_G1_BASE];
   assign base_o[2] = store[SLOT_RG_BASE];
   assign base_o[3] = store[SLOT_IN_BASE];
   assign mask_o[0] = store[SLOT_G0_MASK];
   assign mask_o[1] = store[SLOT_G1_MASK];

   always_comb begin
      rd_mux = '0;
      for (int s = 0; s < NSLOT; s++)
         if (idx == IDX_W'(s)) rd_mux = store[s];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd)
         rdata <= rd_mux;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_o <= 1'b0;
      else if (|err_src)
         err_o <= 1'b1;
   end

   // R3: unimplemented enable bits never become set
   p_en_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      store[SLOT_ENABLE][59:0] == '0);

   // R10: error flag never drops outside reset
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R10: error flag only rises after a write
   p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(wr));

endmodule

// File: rtl/bar_window.sv
module bar_window
   import bar_win_pkg::*;
#(
   parameter win_e KIND     = WIN_GEN0,
   parameter int   ADDR_W   = 64,
   parameter int   NUM_REGS = 2048,
   parameter int   MAX_INTS = 4096
) (
   input  logic              en,
   input  logic [63:0]       base_reg,
   input  logic [63:0]       mask_reg,
   input  logic [ADDR_W-1:0] addr,
   output logic              match,
   output logic [ADDR_W-1:0] offset
);

   localparam int SW = ADDR_W + 1;

   logic [ADDR_W-1:0] base;
   logic [SW-1:0]     size;
   logic [SW-1:0]     limit;
   logic              unused_low;

   assign base = ADDR_W'(base_reg >> 8);

   if (KIND == WIN_GEN0 || KIND == WIN_GEN1) begin : g_masked
      logic [55:0] inv_mask;
      assign inv_mask   = ~mask_reg[63:8];
      assign size       = SW'(inv_mask) + SW'(1);
      assign unused_low = ^{base_reg[7:0], mask_reg[7:0]};
   end else if (KIND == WIN_REGS) begin : g_regs
      localparam logic [SW-1:0] FIX = SW'(NUM_REGS) * SW'(8);
      assign size       = FIX;
      assign unused_low = ^{base_reg[7:0], mask_reg};
   end else begin : g_intr
      localparam logic [SW-1:0] FIX = SW'(MAX_INTS) << 16;
      assign size       = FIX;
      assign unused_low = ^{base_reg[7:0], mask_reg};
   end

   assign limit  = {1'b0, base} + size;
   assign match  = en && (addr >= base) && ({1'b0, addr} < limit);
   assign offset = addr - base;

endmodule

// File: rtl/bar_select.sv
module bar_select
   import bar_win_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          addr_vld,
   input  logic [NWIN-1:0]               match,
   input  logic [NWIN-1:0][ADDR_W-1:0]   offs,
   output logic                          hit_vld,
   output logic [NWIN-1:0]               hit,
   output logic [ADDR_W-1:0]             hit_offset
);

   logic [NWIN-1:0]   win_nxt;
   logic [ADDR_W-1:0] off_nxt;

   // lowest index wins
   always_comb begin
      win_nxt = '0;
      off_nxt = '0;
      for (int w = NWIN-1; w >= 0; w--) begin
         if (match[w]) begin
            win_nxt    = '0;
            win_nxt[w] = 1'b1;
            off_nxt    = offs[w];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_vld    <= 1'b0;
         hit        <= '0;
         hit_offset <= '0;
      end else begin
         hit_vld    <= addr_vld;
         hit        <= addr_vld ? win_nxt : '0;
         hit_offset <= addr_vld ? off_nxt : '0;
      end
   end

   p_onehot_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_vld |-> (hit == '0));

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld |=> hit_vld);

   p_miss_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> (hit_offset == '0));

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
   import bar_win_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int REG_AW   = 6,
   parameter int NUM_REGS = 2048,
   parameter int MAX_INTS = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   input  logic              addr_vld,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_vld,
   output logic [3:0]        hit,
   output logic [ADDR_W-1:0] hit_offset,
   output logic              reprog_err
);

   localparam int IDX_W = REG_AW - 3;

   if (ADDR_W != 64) begin : g_chk_aw
      $error("bar_window_decoder: ADDR_W must be 64");
   end
   if (IDX_W < 3) begin : g_chk_idx
      $error("bar_window_decoder: REG_AW too small for seven slots");
   end
   if (NUM_REGS < 1 || MAX_INTS < 1) begin : g_chk_sz
      $error("bar_window_decoder: fixed window sizes must be non-zero");
   end

   logic [NWIN-1:0][63:0]     base_q;
   logic [1:0][63:0]          mask_q;
   logic [NWIN-1:0]           en_q;
   logic [NWIN-1:0]           match;
   logic [NWIN-1:0][ADDR_W-1:0] offs;
   logic                      unused_byte;

   assign unused_byte = ^reg_addr[2:0];

   bar_regfile #(.IDX_W(IDX_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .rd     (reg_rd),
      .idx    (reg_addr[REG_AW-1:3]),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .base_o (base_q),
      .mask_o (mask_q),
      .en_o   (en_q),
      .err_o  (reprog_err)
   );

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam win_e K = win_e'(w);
      logic [63:0] mask_in;
      if (w < 2) begin : g_m
         assign mask_in = mask_q[w];
      end else begin : g_nm
         assign mask_in = '0;
      end

      bar_window #(
         .KIND     (K),
         .ADDR_W   (ADDR_W),
         .NUM_REGS (NUM_REGS),
         .MAX_INTS (MAX_INTS)
      ) u_win (
         .en       (en_q[w]),
         .base_reg (base_q[w]),
         .mask_reg (mask_in),
         .addr     (addr),
         .match    (match[w]),
         .offset   (offs[w])
      );
   end

   bar_select #(.ADDR_W(ADDR_W)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_vld   (addr_vld),
      .match      (match),
      .offs       (offs),
      .hit_vld    (hit_vld),
      .hit        (hit),
      .hit_offset (hit_offset)
   );

   // R4: a window reported as winner had its enable set when decoded
   p_hit_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vld |-> ((hit & ~$past(en_q)) == '0));

endmodule

// File: tb/bar_window_decoder_tb.sv
module bar_window_decoder_tb;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        addr_vld = 1'b0;
   logic [63:0] addr = '0;
   logic        hit_vld;
   logic [3:0]  hit;
   logic [63:0] hit_offset;
   logic        reprog_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   bar_window_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .addr_vld(addr_vld), .addr(addr), .hit_vld(hit_vld), .hit(hit),
      .hit_offset(hit_offset), .reprog_err(reprog_err)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic wr(input int slot, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 6'(slot * 8); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int slot, input logic [63:0] exp);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 6'(slot * 8);
      @(negedge clk);
      reg_rd = 1'b0;
      chk(req, reg_rdata, exp);
   endtask

   task automatic dec(input string req, input logic [63:0] a,
                      input logic [3:0] exp_hit, input logic [63:0] exp_off);
      @(negedge clk);
      addr_vld = 1'b1; addr = a;
      @(negedge clk);
      addr_vld = 1'b0;
      chk({req, " valid"}, 64'(hit_vld), 64'd1);
      chk({req, " hit"}, 64'(hit), 64'(exp_hit));
      chk({req, " offset"}, hit_offset, exp_off);
   endtask

   // R1, R2: reset state
   task automatic t_reset();
      for (int s = 0; s < 8; s++) rd_chk("R1 reset read", s, 64'h0);
      dec("R1 reset decode", 64'h0, 4'h0, 64'h0);
      chk("R1 reset err", 64'(reprog_err), 64'd0);
   endtask

   // R2, R3: write trimming and slot map
   task automatic t_trim();
      for (int s = 0; s < 8; s++) wr(s, '1);
      rd_chk("R3 gen0 base", 0, 64'hFFFF_FFFF_FF00_0000);
      rd_chk("R3 gen0 mask", 1, 64'hFFFF_FFFF_FF00_0000);
      rd_chk("R3 gen1 base", 2, 64'hFFFF_FFFF_FF00_0000);
      rd_chk("R3 gen1 mask", 3, 64'hFFFF_FFFF_FF00_0000);
      rd_chk("R3 regs base", 4, 64'hFFFF_FFFF_FFC0_0000);
      rd_chk("R3 intr base", 5, 64'hFFFF_FFF0_0000_0000);
      rd_chk("R3 enable", 6, 64'hF000_0000_0000_0000);
      rd_chk("R2 slot7 empty", 7, 64'h0);
      wr(6, 64'h0);
      chk("R10 no err while disabled", 64'(reprog_err), 64'd0);
   endtask

   task automatic t_program();
      wr(0, 64'h0000_0100_0000_0000);
      wr(1, 64'hFFFF_FFFF_0000_0000);
      wr(2, 64'h0000_0100_8000_0000);
      wr(3, 64'hFFFF_FFFF_FF00_0000);
      wr(4, 64'h0000_0200_0000_0000);
      wr(5, 64'h0000_0300_0000_0000);
   endtask

   // R4, R5: general window bounds
   task automatic t_general();
      dec("R4 all disabled", 64'h1_0000_0000, 4'h0, 64'h0);
      wr(6, 64'h8000_0000_0000_0000);
      dec("R5 below base", 64'h0_FFFF_FFFF, 4'h0, 64'h0);
      dec("R5 at base", 64'h1_0000_0000, 4'h1, 64'h0);
      dec("R5 last byte", 64'h1_00FF_FFFF, 4'h1, 64'hFF_FFFF);
      dec("R5 past end", 64'h1_0100_0000, 4'h0, 64'h0);
      dec("R4 gen1 disabled", 64'h1_0080_0000, 4'h1, 64'h80_0000);
   endtask

   // R7, R11: priority and enable changes
   task automatic t_priority();
      wr(6, 64'hF000_0000_0000_0000);
      dec("R7 gen0 over gen1", 64'h1_0080_0010, 4'h1, 64'h80_0010);
      wr(6, 64'h4000_0000_0000_0000);
      dec("R11 gen1 alone", 64'h1_0080_0010, 4'h2, 64'h10);
      dec("R5 gen1 last", 64'h1_0080_FFFF, 4'h2, 64'hFFFF);
      dec("R5 gen1 end", 64'h1_0081_0000, 4'h0, 64'h0);
   endtask

   // R6, R7: fixed windows
   task automatic t_fixed();
      wr(6, 64'h3000_0000_0000_0000);
      dec("R6 regs base", 64'h2_0000_0000, 4'h4, 64'h0);
      dec("R6 regs last", 64'h2_0000_3FFF, 4'h4, 64'h3FFF);
      dec("R6 regs end", 64'h2_0000_4000, 4'h0, 64'h0);
      dec("R6 intr base", 64'h3_0000_0000, 4'h8, 64'h0);
      dec("R6 intr last", 64'h3_0FFF_FFFF, 4'h8, 64'hFFF_FFFF);
      dec("R6 intr end", 64'h3_1000_0000, 4'h0, 64'h0);
      wr(6, 64'h0);
      wr(5, 64'h0000_0200_0000_0000);
      wr(6, 64'h3000_0000_0000_0000);
      dec("R7 regs over intr", 64'h2_0000_0010, 4'h4, 64'h10);
      dec("R8 intr offset", 64'h2_0000_4000, 4'h8, 64'h4000);
      chk("R10 no err so far", 64'(reprog_err), 64'd0);
   endtask

   // R9: outputs drop when no address is presented
   task automatic t_latency();
      dec("R9 one cycle", 64'h2_0000_0008, 4'h4, 64'h8);
      @(negedge clk);
      chk("R9 idle valid", 64'(hit_vld), 64'd0);
      chk("R9 idle hit", 64'(hit), 64'd0);
   endtask

   // R10, R1: reprogramming an enabled window
   task automatic t_error();
      wr(6, 64'h8000_0000_0000_0000);
      wr(3, 64'hFFFF_FFFF_0000_0000);
      chk("R10 disabled write", 64'(reprog_err), 64'd0);
      wr(1, 64'hFFFF_FFFF_FFFF_0000);
      chk("R10 enabled write", 64'(reprog_err), 64'd1);
      rd_chk("R10 still stored", 1, 64'hFFFF_FFFF_FF00_0000);
      dec("R10 new size used", 64'h1_0001_0000, 4'h0, 64'h0);
      wr(6, 64'h0);
      chk("R10 sticky", 64'(reprog_err), 64'd1);
      do_reset();
      chk("R1 reset clears err", 64'(reprog_err), 64'd0);
      rd_chk("R1 reset clears base", 0, 64'h0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      do_reset();
      t_reset();
      t_trim();
      t_program();
      t_general();
      t_priority();
      t_fixed();
      t_latency();
      t_error();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

endmodule